// File: doc/BRIEF.md
# Overlapped Converter Sample Mover

This controller moves one sample per period from a two-channel analog-to-digital front end to a one-channel digital-to-analog back end. Each converter sits behind its own datapath, which is reached through a request/done handshake. The two serial links are separate, so the controller starts the ADC acquisition and the DAC write in the same cycle and lets them run side by side.

The two transfers are staggered by one sample. While the ADC acquires sample N, the DAC is writing sample N-1. A select input picks which of the two ADC channels is forwarded. Samples are 12-bit straight binary at both ends and are passed on bit for bit. A one-cycle strobe marks the start of every sample period, so the achieved sample rate can be measured on a pin.

Top module: `sample_pipe_ctrl`

## Requirements
- R1: The ADC request and the DAC request rise in the same cycle.
- R2: A request stays high until its done input is sampled high while the request is high. The request is low in the next cycle.
- R3: A new pair of requests rises exactly one cycle after the later of the two done inputs is seen. No request rises before both done inputs of the current pair have been seen.
- R4: The DAC word presented with pair N equals the selected-channel sample captured during pair N-1. The ADC sample is captured in the cycle its done is seen. The DAC word stays constant while the DAC request is high.
- R5: After reset the first DAC word is zero.
- R6: The channel select is sampled in the cycle the requests are launched. A value of 0 selects channel 0 and 1 selects channel 1. Changing the select while a transfer is in flight does not change which channel that transfer forwards.
- R7: The forwarded sample reaches the DAC port unchanged in all 12 bits.
- R8: The conversion strobe is high for exactly one cycle per sample, in the first cycle in which the requests are high.
- R9: While reset is low, both requests, the strobe and the DAC word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_sel | input | 1 | Channel select (0: channel 0, 1: channel 1) |
| adc_req | output | 1 | Start request to the ADC datapath |
| adc_done | input | 1 | ADC datapath completion status |
| adc_ch0 | input | SAMPLE_W | ADC channel 0 sample |
| adc_ch1 | input | SAMPLE_W | ADC channel 1 sample |
| dac_req | output | 1 | Start request to the DAC datapath |
| dac_done | input | 1 | DAC datapath completion status |
| dac_data | output | SAMPLE_W | Word for the DAC datapath |
| conv_strobe | output | 1 | One-cycle pulse per sample period |

## Verification
The assertions assume that each datapath raises done only while its request is high, and holds done for no more than the cycle in which it is seen. They also assume that the channel data is valid in the cycle the ADC done is seen. The stub tasks in the bench raise done only after a per-sample latency, counted from a launch they observed, and drop it one cycle later. The bench changes the channel data and the select only at a launch. It varies the ADC and DAC latencies independently, including zero and unequal values, so that either side can finish first.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic {PH_LAUNCH = 1'b0, PH_WAIT = 1'b1} phase_t;

  // a side counts as finished if it finished earlier or finishes now
  function automatic logic pair_complete(input logic a_fin, input logic a_evt,
                                         input logic b_fin, input logic b_evt);
    return (a_fin | a_evt) & (b_fin | b_evt);
  endfunction
endpackage

// File: rtl/spc_req_tracker.sv
module spc_req_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  output logic req,
  output logic fin,
  output logic evt
);
  assign evt = req & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      fin <= 1'b0;
    end else if (launch) begin
      req <= 1'b1;
      fin <= 1'b0;
    end else if (evt) begin
      req <= 1'b0;
      fin <= 1'b1;
    end
  end

  // R2: hold until done is seen
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done && !launch) |=> req);
  // R2: drop one cycle after done is seen
  a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done) |=> !req);
endmodule

// File: rtl/spc_sample_store.sv
module spc_sample_store #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                ch_sel,
  input  logic                capture,
  input  logic [SAMPLE_W-1:0] ch0,
  input  logic [SAMPLE_W-1:0] ch1,
  output logic [SAMPLE_W-1:0] dac_word
);
  logic                sel_q;
  logic [SAMPLE_W-1:0] held_q;

  function automatic logic [SAMPLE_W-1:0] pick(input logic s,
      input logic [SAMPLE_W-1:0] a, input logic [SAMPLE_W-1:0] b);
    return s ? b : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      held_q   <= '0;
      dac_word <= '0;
    end else begin
      if (launch) begin
        sel_q    <= ch_sel;
        dac_word <= held_q;
      end
      if (capture) held_q <= pick(sel_q, ch0, ch1);
    end
  end

  // R4: DAC word only moves at a launch
  a_r4_word_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(dac_word));
  // R6: selection only moves at a launch
  a_r6_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sel_q));
endmodule

// File: rtl/sample_pipe_ctrl.sv
module sample_pipe_ctrl #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch_sel,
  output logic                adc_req,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_ch0,
  input  logic [SAMPLE_W-1:0] adc_ch1,
  output logic                dac_req,
  input  logic                dac_done,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                conv_strobe
);
  import spc_pkg::*;

  phase_t phase_q;
  logic   launch;
  logic   adc_fin, adc_evt, dac_fin, dac_evt;
  logic   pair_done;

  assign launch    = (phase_q == PH_LAUNCH);
  assign pair_done = pair_complete(adc_fin, adc_evt, dac_fin, dac_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_LAUNCH;
      conv_strobe <= 1'b0;
    end else begin
      conv_strobe <= launch;
      case (phase_q)
        PH_LAUNCH: phase_q <= PH_WAIT;
        default:   if (pair_done) phase_q <= PH_LAUNCH;
      endcase
    end
  end

  spc_req_tracker u_adc_trk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .done(adc_done),
    .req(adc_req), .fin(adc_fin), .evt(adc_evt)
  );

  spc_req_tracker u_dac_trk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .done(dac_done),
    .req(dac_req), .fin(dac_fin), .evt(dac_evt)
  );

  spc_sample_store #(.SAMPLE_W(SAMPLE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .launch(launch), .ch_sel(ch_sel),
    .capture(adc_evt), .ch0(adc_ch0), .ch1(adc_ch1), .dac_word(dac_data)
  );

  // R1: both requests rise together, with the strobe
  a_r1_pair_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_req) |-> ($rose(dac_req) && conv_strobe));
  // R3: no launch while either side is still busy
  a_r3_wait_both: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!adc_req && !dac_req));
  // R8: strobe lasts one cycle and coincides with live requests
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> (adc_req && dac_req) ##1 !conv_strobe);
endmodule

// File: tb/sample_pipe_ctrl_test.sv
module sample_pipe_ctrl_test;
  localparam int W = 12;
  localparam int NV = 10;
  // {sel, ch0, ch1, adc latency, dac latency}
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 12'h123, 12'h456, 4'd3, 4'd1},
    {1'b1, 12'hABC, 12'h0F0, 4'd1, 4'd4},
    {1'b1, 12'hFFF, 12'h000, 4'd0, 4'd0},
    {1'b0, 12'h000, 12'hFFF, 4'd2, 4'd2},
    {1'b0, 12'hFFF, 12'h555, 4'd5, 4'd0},
    {1'b1, 12'h5A5, 12'hA5A, 4'd0, 4'd6},
    {1'b0, 12'h800, 12'h7FF, 4'd1, 4'd1},
    {1'b1, 12'h001, 12'h800, 4'd4, 4'd3},
    {1'b0, 12'h3C3, 12'hC3C, 4'd2, 4'd0},
    {1'b1, 12'h111, 12'hEEE, 4'd1, 4'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, ch_sel = 1'b0;
  logic adc_done = 1'b0, dac_done = 1'b0;
  logic [W-1:0] adc_ch0 = '0, adc_ch1 = '0;
  logic adc_req, dac_req, conv_strobe;
  logic [W-1:0] dac_data;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [W-1:0] exp_word = '0;

  always #5 clk = ~clk;

  sample_pipe_ctrl #(.SAMPLE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ch_sel(ch_sel), .adc_req(adc_req),
    .adc_done(adc_done), .adc_ch0(adc_ch0), .adc_ch1(adc_ch1),
    .dac_req(dac_req), .dac_done(dac_done), .dac_data(dac_data),
    .conv_strobe(conv_strobe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adc_serve(input int lat);
    repeat (lat) @(negedge clk);
    chk(adc_req == 1'b1, "R2 adc req held", adc_req, 1);
    adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
    chk(adc_req == 1'b0, "R2 adc req dropped", adc_req, 0);
  endtask

  task automatic dac_serve(input int lat);
    repeat (lat) @(negedge clk);
    chk(dac_req == 1'b1, "R2 dac req held", dac_req, 1);
    chk(dac_data == exp_word, "R4 dac word steady", dac_data, exp_word);
    dac_done = 1'b1;
    @(negedge clk);
    dac_done = 1'b0;
    chk(dac_req == 1'b0, "R2 dac req dropped", dac_req, 0);
  endtask

  // at a launch negedge: strobe, both requests, expected word (R1, R4, R7, R8)
  task automatic chk_launch(input string tag);
    chk(conv_strobe == 1'b1, {tag, " R8 strobe"}, conv_strobe, 1);
    chk(adc_req && dac_req, {tag, " R1 both req"}, {adc_req, dac_req}, 3);
    chk(dac_data == exp_word, {tag, " R4 R7 dac word"}, dac_data, exp_word);
  endtask

  // one sample: present data, pre-set the next select, serve both sides
  task automatic run_sample(input logic [32:0] v, input logic next_sel);
    adc_ch0 = v[31:20];
    adc_ch1 = v[19:8];
    ch_sel  = next_sel;       // mid-transfer change, R6
    fork
      adc_serve(int'(v[7:4]));
      dac_serve(int'(v[3:0]));
      begin
        @(negedge clk);
        chk(conv_strobe == 1'b0, "R8 strobe one cycle", conv_strobe, 0);
      end
    join
    chk(conv_strobe == 1'b0 && !adc_req && !dac_req, "R3 no early launch",
        {conv_strobe, adc_req, dac_req}, 0);
    exp_word = v[32] ? v[19:8] : v[31:20];
    @(negedge clk);
  endtask

  initial begin
    ch_sel = VEC[0][32];
    repeat (3) @(negedge clk);
    chk(!adc_req && !dac_req && !conv_strobe && dac_data == '0, "R9 reset state",
        {adc_req, dac_req, conv_strobe, dac_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_word = '0;
    chk_launch("R5 first");
    for (int n = 0; n < NV; n++) begin
      run_sample(VEC[n], (n + 1 < NV) ? VEC[n + 1][32] : VEC[n][32]);
      chk_launch("R3 relaunch");
    end
    // reset during a transfer
    rst_n = 1'b0;
    @(negedge clk);
    chk(!adc_req && !dac_req && !conv_strobe && dac_data == '0, "R9 mid reset",
        {adc_req, dac_req, conv_strobe, dac_data}, 0);
    ch_sel = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    exp_word = '0;
    chk_launch("R5 after reset");
    run_sample({1'b1, 12'h0AA, 12'hB0B, 4'd2, 4'd2}, 1'b0);
    chk_launch("R6 sel one");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule